// File: doc/BRIEF.md
# Warp Divergence Stack Controller

This block steers control flow for a group of threads that share one instruction stream. It keeps the group's program counter, an active-thread mask and a fixed-depth stack of reconvergence records, each record holding a resume address and a thread mask. For every accepted instruction it works out the next address and the next active mask. Ordinary instructions step the address by one. Three control operations change the flow: saving a reconvergence point, a conditional branch that takes a per-thread predicate, and restoring a saved record.

When a branch finds active threads on both sides, the deferred side is saved on the stack with its own mask. The fall-through side runs first under the predicate mask. A restore then starts the deferred side, and a final restore brings back the full mask at the join address. So both sides run one after the other and the threads then reconverge. Stack misuse is caught by two sticky error flags and does no damage.

Top module: `warp_reconv_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `pc` is zero, `active_mask` is all ones, the stack is empty and both error flags are low.
- R2: An accepted instruction with `op` = 2'b00 sets `pc` to `pc`+1 and leaves the mask unchanged. When `instr_valid` is low, `pc`, the mask and the stack do not change.
- R3: `op` = 2'b01 (save) puts the pair (`target_pc`, current mask) on top of the stack and sets `pc` to `pc`+1.
- R4: For `op` = 2'b10 (branch), the fall-through set is `pred` AND mask and the else set is NOT `pred` AND mask. When both sets are non-empty, the pair (`target_pc`, else set) is pushed, the mask becomes the fall-through set and `pc` becomes `pc`+1.
- R5: A branch with an empty fall-through set pushes nothing, sets the mask to the else set and loads `pc` with `target_pc`.
- R6: A branch with an empty else set pushes nothing, keeps the mask and sets `pc` to `pc`+1.
- R7: `op` = 2'b11 (restore) on a non-empty stack loads `pc` and the mask from the top record and removes that record. Records come back in last-in, first-out order.
- R8: A save, or a branch that would push, while the stack holds DEPTH records leaves the stack and the mask unchanged, sets `pc` to `pc`+1 and sets `overflow_err`, which stays high until reset.
- R9: A restore on an empty stack leaves the mask unchanged, sets `pc` to `pc`+1 and sets `underflow_err`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | An instruction is presented this cycle |
| op | input | 2 | 00 ordinary, 01 save, 10 branch, 11 restore |
| target_pc | input | PC_W | Join address for save, else address for branch |
| pred | input | NTHR | Per-thread branch predicate, 1 = fall through |
| pc | output | PC_W | Current program counter |
| active_mask | output | NTHR | Current active-thread mask |
| overflow_err | output | 1 | Sticky: a push was refused on a full stack |
| underflow_err | output | 1 | Sticky: a restore was refused on an empty stack |

## Verification
Any fault in the stack shows up at the ports only when a restore is issued. A record with a corrupt mask or address, or a record left over from a refused push, appears on `pc` and `active_mask` in the cycle after that restore. The stimulus therefore nests branches three deep and drains every level, so each stored record is compared. A wrong split decision shows at once: the mask or the address is wrong in the cycle after the branch.

// File: rtl/warp_reconv_pkg.sv
package warp_reconv_pkg;

    typedef enum logic [1:0] {
        OP_PLAIN   = 2'b00,
        OP_SAVE    = 2'b01,
        OP_BRANCH  = 2'b10,
        OP_RESTORE = 2'b11
    } ctrl_op_e;

    typedef enum logic [1:0] {
        SPLIT_BOTH   = 2'b00,
        SPLIT_ELSE   = 2'b01,
        SPLIT_THRU   = 2'b10
    } split_kind_e;

    // Decide how a branch divides the active threads.
    function automatic split_kind_e classify_split(input logic any_thru,
                                                   input logic any_else);
        if (!any_thru)
            return SPLIT_ELSE;
        else if (!any_else)
            return SPLIT_THRU;
        else
            return SPLIT_BOTH;
    endfunction

endpackage

// File: rtl/mask_splitter.sv
module mask_splitter
    import warp_reconv_pkg::*;
#(
    parameter int NTHR = 8
) (
    input  logic [NTHR-1:0] cur_mask,
    input  logic [NTHR-1:0] pred,
    output logic [NTHR-1:0] thru_mask,
    output logic [NTHR-1:0] else_mask,
    output split_kind_e     kind
);

    always_comb begin
        thru_mask = pred & cur_mask;
        else_mask = ~pred & cur_mask;
        kind      = classify_split(|thru_mask, |else_mask);
    end

endmodule

// File: rtl/reconv_stack.sv
module reconv_stack #(
    parameter int PC_W  = 16,
    parameter int NTHR  = 8,
    parameter int DEPTH = 4,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic [PC_W-1:0]  push_pc,
    input  logic [NTHR-1:0]  push_mask,
    output logic [PC_W-1:0]  top_pc,
    output logic [NTHR-1:0]  top_mask,
    output logic             full,
    output logic             empty,
    output logic [LVL_W-1:0] level
);

    logic [LVL_W-1:0] level_q;
    logic [PC_W-1:0]  ent_pc   [DEPTH];
    logic [NTHR-1:0]  ent_mask [DEPTH];
    logic [IDX_W-1:0] top_idx;

    assign empty = (level_q == '0);
    assign full  = (level_q == LVL_W'(DEPTH));
    assign level = level_q;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [PC_W-1:0] slot_pc;
        logic [NTHR-1:0] slot_mask;

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_pc   <= '0;
                slot_mask <= '0;
            end else if (push && !full && level_q == LVL_W'(i)) begin
                slot_pc   <= push_pc;
                slot_mask <= push_mask;
            end
        end

        assign ent_pc[i]   = slot_pc;
        assign ent_mask[i] = slot_mask;
    end

    always_comb begin
        if (empty)
            top_idx = '0;
        else
            top_idx = IDX_W'(level_q - LVL_W'(1));
        top_pc   = ent_pc[top_idx];
        top_mask = ent_mask[top_idx];
    end

    always_ff @(posedge clk) begin
        if (rst)
            level_q <= '0;
        else if (push && !full)
            level_q <= level_q + LVL_W'(1);
        else if (pop && !empty)
            level_q <= level_q - LVL_W'(1);
    end

endmodule

// File: rtl/warp_reconv_ctrl.sv
module warp_reconv_ctrl
    import warp_reconv_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int NTHR  = 8,
    parameter int DEPTH = 4,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            instr_valid,
    input  logic [1:0]      op,
    input  logic [PC_W-1:0] target_pc,
    input  logic [NTHR-1:0] pred,
    output logic [PC_W-1:0] pc,
    output logic [NTHR-1:0] active_mask,
    output logic            overflow_err,
    output logic            underflow_err
);

    logic [PC_W-1:0]  pc_q, pc_n;
    logic [NTHR-1:0]  mask_q, mask_n;
    logic             ovf_q, udf_q, ovf_set, udf_set;

    logic             stk_push, stk_pop;
    logic [PC_W-1:0]  stk_push_pc, stk_top_pc;
    logic [NTHR-1:0]  stk_push_mask, stk_top_mask;
    logic             stk_full, stk_empty;
    logic [LVL_W-1:0] stk_level;

    logic [NTHR-1:0]  thru_mask, else_mask;
    split_kind_e      kind;
    ctrl_op_e         op_e;
    logic [PC_W-1:0]  pc_step;

    assign op_e    = ctrl_op_e'(op);
    assign pc_step = pc_q + PC_W'(1);

    mask_splitter #(.NTHR(NTHR)) u_split (
        .cur_mask  (mask_q),
        .pred      (pred),
        .thru_mask (thru_mask),
        .else_mask (else_mask),
        .kind      (kind)
    );

    reconv_stack #(.PC_W(PC_W), .NTHR(NTHR), .DEPTH(DEPTH)) u_stack (
        .clk       (clk),
        .rst       (rst),
        .push      (stk_push),
        .pop       (stk_pop),
        .push_pc   (stk_push_pc),
        .push_mask (stk_push_mask),
        .top_pc    (stk_top_pc),
        .top_mask  (stk_top_mask),
        .full      (stk_full),
        .empty     (stk_empty),
        .level     (stk_level)
    );

    always_comb begin
        pc_n          = pc_q;
        mask_n        = mask_q;
        stk_push      = 1'b0;
        stk_pop       = 1'b0;
        stk_push_pc   = target_pc;
        stk_push_mask = mask_q;
        ovf_set       = 1'b0;
        udf_set       = 1'b0;
        if (instr_valid) begin
            unique case (op_e)
                OP_PLAIN: begin
                    pc_n = pc_step;
                end
                OP_SAVE: begin
                    pc_n = pc_step;
                    if (stk_full)
                        ovf_set = 1'b1;
                    else
                        stk_push = 1'b1;
                end
                OP_BRANCH: begin
                    unique case (kind)
                        SPLIT_ELSE: begin
                            pc_n   = target_pc;
                            mask_n = else_mask;
                        end
                        SPLIT_THRU: begin
                            pc_n = pc_step;
                        end
                        default: begin
                            pc_n = pc_step;
                            if (stk_full) begin
                                ovf_set = 1'b1;
                            end else begin
                                stk_push      = 1'b1;
                                stk_push_mask = else_mask;
                                mask_n        = thru_mask;
                            end
                        end
                    endcase
                end
                OP_RESTORE: begin
                    if (stk_empty) begin
                        udf_set = 1'b1;
                        pc_n    = pc_step;
                    end else begin
                        stk_pop = 1'b1;
                        pc_n    = stk_top_pc;
                        mask_n  = stk_top_mask;
                    end
                end
                default: pc_n = pc_step;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            mask_q <= '1;
            ovf_q  <= 1'b0;
            udf_q  <= 1'b0;
        end else begin
            pc_q   <= pc_n;
            mask_q <= mask_n;
            ovf_q  <= ovf_q | ovf_set;
            udf_q  <= udf_q | udf_set;
        end
    end

    assign pc            = pc_q;
    assign active_mask   = mask_q;
    assign overflow_err  = ovf_q;
    assign underflow_err = udf_q;

endmodule

// File: rtl/warp_reconv_chk.sv
module warp_reconv_chk #(
    parameter int PC_W  = 16,
    parameter int NTHR  = 8,
    parameter int DEPTH = 4,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             instr_valid,
    input logic [1:0]       op,
    input logic [PC_W-1:0]  pc,
    input logic [NTHR-1:0]  active_mask,
    input logic             overflow_err,
    input logic             underflow_err,
    input logic [LVL_W-1:0] level
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (pc == '0 && active_mask == '1 && level == '0
                 && !overflow_err && !underflow_err));

    // R2
    plain_step_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && op == 2'b00) |=>
            (pc == $past(pc) + PC_W'(1) && $stable(active_mask)));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> ($stable(pc) && $stable(active_mask) && $stable(level)));

    // R3
    save_grow_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && op == 2'b01 && level != LVL_W'(DEPTH)) |=>
            (level == $past(level) + LVL_W'(1)));

    // R4
    branch_narrow_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && op == 2'b10) |=>
            ((active_mask & ~$past(active_mask)) == '0));

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        level <= LVL_W'(DEPTH));

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overflow_err |=> overflow_err);

    // R9
    udf_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && op == 2'b11 && level == '0) |=>
            (underflow_err && $stable(active_mask)));

    // R9
    udf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        underflow_err |=> underflow_err);

endmodule

bind warp_reconv_ctrl warp_reconv_chk #(
    .PC_W(PC_W), .NTHR(NTHR), .DEPTH(DEPTH)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .instr_valid   (instr_valid),
    .op            (op),
    .pc            (pc),
    .active_mask   (active_mask),
    .overflow_err  (overflow_err),
    .underflow_err (underflow_err),
    .level         (stk_level)
);

// File: tb/sim_warp_reconv_ctrl.sv
`timescale 1ns/1ps
module sim_warp_reconv_ctrl;

    localparam int PC_W  = 16;
    localparam int NTHR  = 8;
    localparam int DEPTH = 4;
    localparam int NVEC  = 21;

    typedef struct packed {
        logic [1:0]  op;
        logic [15:0] tgt;
        logic [7:0]  pred;
        logic [15:0] epc;
        logic [7:0]  emask;
    } vec_t;

    // op: 0 plain, 1 save, 2 branch, 3 restore
    localparam vec_t VECS [NVEC] = '{
        '{2'd1, 16'h0040, 8'h00, 16'h0001, 8'hFF},  // R3 save join
        '{2'd2, 16'h0020, 8'h0F, 16'h0002, 8'h0F},  // R4 split
        '{2'd0, 16'h0000, 8'h00, 16'h0003, 8'h0F},  // R2 plain
        '{2'd3, 16'h0000, 8'h00, 16'h0020, 8'hF0},  // R7 else side
        '{2'd0, 16'h0000, 8'h00, 16'h0021, 8'hF0},  // R2
        '{2'd3, 16'h0000, 8'h00, 16'h0040, 8'hFF},  // R7 reconverge
        '{2'd1, 16'h0080, 8'h00, 16'h0041, 8'hFF},  // R3
        '{2'd2, 16'h0060, 8'h00, 16'h0060, 8'hFF},  // R5 all else
        '{2'd3, 16'h0000, 8'h00, 16'h0080, 8'hFF},  // R7
        '{2'd1, 16'h0090, 8'h00, 16'h0081, 8'hFF},  // R3
        '{2'd2, 16'h0070, 8'hFF, 16'h0082, 8'hFF},  // R6 all thru
        '{2'd2, 16'h0075, 8'h3C, 16'h0083, 8'h3C},  // R4 outer split
        '{2'd2, 16'h0078, 8'h0C, 16'h0084, 8'h0C},  // R4 nested split
        '{2'd3, 16'h0000, 8'h00, 16'h0078, 8'h30},  // R7 inner else
        '{2'd3, 16'h0000, 8'h00, 16'h0075, 8'hC3},  // R7 outer else
        '{2'd3, 16'h0000, 8'h00, 16'h0090, 8'hFF},  // R7 join
        '{2'd1, 16'h00A0, 8'h00, 16'h0091, 8'hFF},  // R3
        '{2'd2, 16'h0095, 8'h01, 16'h0092, 8'h01},  // R4
        '{2'd2, 16'h0099, 8'hFE, 16'h0099, 8'h01},  // R5 pred only on inactive
        '{2'd3, 16'h0000, 8'h00, 16'h0095, 8'hFE},  // R7
        '{2'd3, 16'h0000, 8'h00, 16'h00A0, 8'hFF}   // R7
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            instr_valid = 1'b0;
    logic [1:0]      op = 2'b00;
    logic [PC_W-1:0] target_pc = '0;
    logic [NTHR-1:0] pred = '0;
    logic [PC_W-1:0] pc;
    logic [NTHR-1:0] active_mask;
    logic            overflow_err, underflow_err;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    warp_reconv_ctrl #(.PC_W(PC_W), .NTHR(NTHR), .DEPTH(DEPTH)) u0 (
        .clk           (clk),
        .rst           (rst),
        .instr_valid   (instr_valid),
        .op            (op),
        .target_pc     (target_pc),
        .pred          (pred),
        .pc            (pc),
        .active_mask   (active_mask),
        .overflow_err  (overflow_err),
        .underflow_err (underflow_err)
    );

    task automatic expect_state(input string req, input logic [PC_W-1:0] epc,
                                input logic [NTHR-1:0] emask,
                                input logic eovf, input logic eudf);
        n_chk++;
        if (pc !== epc || active_mask !== emask ||
            overflow_err !== eovf || underflow_err !== eudf) begin
            n_fail++;
            $display("FAIL %s: got pc=%h mask=%h ovf=%b udf=%b, expected pc=%h mask=%h ovf=%b udf=%b",
                     req, pc, active_mask, overflow_err, underflow_err,
                     epc, emask, eovf, eudf);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic issue(input logic [1:0] o, input logic [PC_W-1:0] t,
                         input logic [NTHR-1:0] p);
        instr_valid = 1'b1;
        op          = o;
        target_pc   = t;
        pred        = p;
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got run still busy, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        expect_state("R1 reset state", 16'h0000, 8'hFF, 1'b0, 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            issue(VECS[i].op, VECS[i].tgt, VECS[i].pred);
            expect_state($sformatf("vector %0d (R2..R7)", i),
                         VECS[i].epc, VECS[i].emask, 1'b0, 1'b0);
        end

        // R9: restore on an empty stack
        issue(2'd3, 16'h0000, 8'h00);
        expect_state("R9 restore on empty", 16'h00A1, 8'hFF, 1'b0, 1'b1);

        // R2: no valid instruction holds state
        @(negedge clk);
        expect_state("R2 idle hold", 16'h00A1, 8'hFF, 1'b0, 1'b1);

        // R1: reset clears flags and state mid-run
        do_reset();
        expect_state("R1 reset clears", 16'h0000, 8'hFF, 1'b0, 1'b0);

        // R8: fill stack, then overfill
        for (int k = 0; k < DEPTH; k++)
            issue(2'd1, PC_W'(16'h0010 + k), 8'h00);
        expect_state("R3 stack filled", 16'h0004, 8'hFF, 1'b0, 1'b0);
        issue(2'd1, 16'h0014, 8'h00);
        expect_state("R8 save on full", 16'h0005, 8'hFF, 1'b1, 1'b0);
        issue(2'd2, 16'h0050, 8'h0F);
        expect_state("R8 split on full", 16'h0006, 8'hFF, 1'b1, 1'b0);
        issue(2'd3, 16'h0000, 8'h00);
        expect_state("R8 refused save not stored", 16'h0013, 8'hFF, 1'b1, 1'b0);

        // R7: remaining records in LIFO order
        issue(2'd3, 16'h0000, 8'h00);
        expect_state("R7 lifo 2", 16'h0012, 8'hFF, 1'b1, 1'b0);
        issue(2'd3, 16'h0000, 8'h00);
        issue(2'd3, 16'h0000, 8'h00);
        expect_state("R7 lifo last", 16'h0010, 8'hFF, 1'b1, 1'b0);

        // R6 with narrowed mask: branch whose else side is empty
        do_reset();
        issue(2'd1, 16'h0030, 8'h00);
        issue(2'd2, 16'h0020, 8'hAA);
        expect_state("R4 split AA", 16'h0002, 8'hAA, 1'b0, 1'b0);
        issue(2'd2, 16'h0028, 8'hAB);
        expect_state("R6 else empty under mask", 16'h0003, 8'hAA, 1'b0, 1'b0);
        issue(2'd3, 16'h0000, 8'h00);
        expect_state("R6 no push happened", 16'h0020, 8'h55, 1'b0, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule